// File: doc/BRIEF.md
# CBR Refresh Scheduler

This block keeps a DRAM array refreshed by issuing CAS-before-RAS refresh cycles on control strobes that it shares with an access controller. An interval timer adds one owed refresh each refresh interval, by default 15.6 µs, so that 4096 rows are covered in 64 ms. While at least one refresh is owed, the block raises a bus request. It takes the strobes only when the access controller grants the bus and reports that its open row has been closed.

During a refresh cycle the block drives RAS, CAS and WE, and `own_o` tells the surrounding mux to pass them to the pins. No address is driven, because the DRAM steps its own internal row counter. The owed count saturates at a limit, by default 8. When that limit is reached the block raises an urgency flag that the access controller must honour. All phase lengths are derived from nanosecond parameters and the clock period, rounded up to whole cycles.

Top module: `cbr_refresh_sched`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `ras_n_o`, `cas_n_o` and `we_n_o` are 1, and `req_o`, `own_o`, `urgent_o` and `done_o` are 0.
- R2: One owed refresh is added every REFI cycles (REFI = ceil(T_REFI_NS/CLK_NS)). After reset is released, `req_o` stays low for the first REFI-1 rising edges and is high after edge REFI.
- R3: A refresh cycle starts only on an edge where `req_o`, `gnt_i` and `row_closed_i` are all high. A grant while `row_closed_i` is low leaves `own_o` at 0 and all strobes high.
- R4: A refresh cycle opens with CSR cycles of `cas_n_o`=0 and `ras_n_o`=1. `ras_n_o` then falls while `cas_n_o` is still low, and `cas_n_o` stays low for the first CHR cycles of the RAS-low phase.
- R5: `ras_n_o` stays low for exactly RASC cycles. A precharge of RPC cycles then follows, with `ras_n_o` and `cas_n_o` both at 1 and `own_o` still at 1. `own_o` is therefore high for CSR+RASC+RPC cycles in total.
- R6: `we_n_o` is 1 on every cycle in which `own_o` is 1.
- R7: `done_o` is a one-cycle pulse on the last owned cycle of each refresh, once per refresh.
- R8: The owed count saturates at MAX_OWED; ticks that arrive while it is full are lost. `urgent_o` is 1 exactly when the count equals MAX_OWED. A full backlog drains in exactly MAX_OWED refreshes if no tick arrives during the drain.
- R9: The owed count drops by one when a refresh starts. `req_o` is 0 while `own_o` is 1. If refreshes are still owed, `req_o` returns to 1 in the cycle after `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gnt_i | input | 1 | Bus grant from the access controller |
| row_closed_i | input | 1 | Access controller has precharged its open row |
| req_o | output | 1 | Refresh owed, bus requested |
| urgent_o | output | 1 | Owed count at its limit, priority demanded |
| own_o | output | 1 | Block drives the control strobes this cycle |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, held high during refresh |
| done_o | output | 1 | Last cycle of a refresh cycle |

## Verification
The bench measures the strobe order cycle by cycle. A design that raised RAS before CAS, or released CAS together with RAS, would issue a normal access or an undefined cycle instead of a refresh. Another test grants the bus while the row is still open. A scheduler that ignored the row-closed qualifier would break an open page. The bench also lets the backlog overflow its limit and then counts the drained refreshes. An unsaturated or wrapping counter would give more or fewer than the limit, and an off-by-one timer would move the first request edge.

// File: rtl/cbr_refresh_pkg.sv
package cbr_refresh_pkg;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_CAS_LEAD,
        PH_RAS_LOW,
        PH_PRECHARGE
    } phase_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
    } strobes_t;

    localparam strobes_t STROBES_IDLE = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};

    // round a time up to whole clock cycles, never below one cycle
    function automatic int ns_to_cyc(input int t_ns, input int clk_ns);
        int c;
        c = (t_ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/refresh_interval_timer.sv
module refresh_interval_timer #(
    parameter int INTERVAL = 1560
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    localparam int TW = $clog2(INTERVAL + 1);
    localparam logic [TW-1:0] LAST = TW'(INTERVAL - 1);

    logic [TW-1:0] cnt_q;

    assign tick_o = (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_TIMER_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST); // R2
endmodule

// File: rtl/owed_refresh_counter.sv
module owed_refresh_counter #(
    parameter int LIMIT = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic add_i,
    input  logic take_i,
    output logic pending_o,
    output logic full_o
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] TOP = CW'(LIMIT);

    logic [CW-1:0] owed_q;

    assign pending_o = (owed_q != '0);
    assign full_o    = (owed_q == TOP);

    always_ff @(posedge clk) begin
        if (rst) begin
            owed_q <= '0;
        end else begin
            unique case ({add_i && !full_o, take_i})
                2'b10:   owed_q <= owed_q + 1'b1;
                2'b01:   owed_q <= owed_q - 1'b1;
                default: owed_q <= owed_q;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        owed_q <= TOP); // R8
    AST_TAKE_NEEDS_OWED: assert property (@(posedge clk) disable iff (rst)
        take_i |-> pending_o); // R9
    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (full_o && add_i && !take_i) |=> full_o); // R8
endmodule

// File: rtl/cbr_sequencer.sv
module cbr_sequencer
    import cbr_refresh_pkg::*;
#(
    parameter int CSR_CYC = 1,
    parameter int CHR_CYC = 1,
    parameter int RAS_CYC = 6,
    parameter int RP_CYC  = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     pending_i,
    input  logic     gnt_i,
    input  logic     row_closed_i,
    output logic     req_o,
    output logic     start_o,
    output logic     own_o,
    output logic     done_o,
    output strobes_t strobes_o
);
    localparam int LONGEST = max3(CSR_CYC, RAS_CYC, RP_CYC);
    localparam int PW      = $clog2(LONGEST + 1);
    localparam logic [PW-1:0] CSR_END = PW'(CSR_CYC - 1);
    localparam logic [PW-1:0] RAS_END = PW'(RAS_CYC - 1);
    localparam logic [PW-1:0] RP_END  = PW'(RP_CYC - 1);
    localparam logic [PW-1:0] CHR_LIM = PW'(CHR_CYC);

    phase_e        phase_q;
    logic [PW-1:0] cnt_q;

    assign req_o   = pending_i && (phase_q == PH_IDLE);
    assign start_o = req_o && gnt_i && row_closed_i;
    assign own_o   = (phase_q != PH_IDLE);
    assign done_o  = (phase_q == PH_PRECHARGE) && (cnt_q == RP_END);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            unique case (phase_q)
                PH_IDLE: begin
                    cnt_q <= '0;
                    if (start_o) phase_q <= PH_CAS_LEAD;
                end
                PH_CAS_LEAD: begin
                    if (cnt_q == CSR_END) begin
                        phase_q <= PH_RAS_LOW;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_RAS_LOW: begin
                    if (cnt_q == RAS_END) begin
                        phase_q <= PH_PRECHARGE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_PRECHARGE: begin
                    if (cnt_q == RP_END) begin
                        phase_q <= PH_IDLE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    phase_q <= PH_IDLE;
                    cnt_q   <= '0;
                end
            endcase
        end
    end

    always_comb begin
        strobes_o = STROBES_IDLE;
        unique case (phase_q)
            PH_CAS_LEAD: strobes_o.cas_n = 1'b0;
            PH_RAS_LOW: begin
                strobes_o.ras_n = 1'b0;
                strobes_o.cas_n = !(cnt_q < CHR_LIM);
            end
            default: ;
        endcase
    end

    AST_CAS_BEFORE_RAS: assert property (@(posedge clk) disable iff (rst)
        $fell(strobes_o.ras_n) |-> (!strobes_o.cas_n && $past(!strobes_o.cas_n))); // R4
    AST_GRANT_GUARD: assert property (@(posedge clk) disable iff (rst)
        $rose(own_o) |-> $past(gnt_i && row_closed_i && pending_i)); // R3
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> (!done_o && !own_o)); // R7
    AST_NO_REQ_BUSY: assert property (@(posedge clk) disable iff (rst)
        own_o |-> !req_o); // R9
    AST_WE_HELD: assert property (@(posedge clk) disable iff (rst)
        own_o |-> strobes_o.we_n); // R6
endmodule

// File: rtl/cbr_refresh_sched.sv
module cbr_refresh_sched
    import cbr_refresh_pkg::*;
#(
    parameter int CLK_NS     = 10,
    parameter int T_REFI_NS  = 15600,
    parameter int T_CSR_NS   = 10,
    parameter int T_CHR_NS   = 10,
    parameter int T_RAS_NS   = 60,
    parameter int T_RP_NS    = 40,
    parameter int MAX_OWED   = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic gnt_i,
    input  logic row_closed_i,
    output logic req_o,
    output logic urgent_o,
    output logic own_o,
    output logic ras_n_o,
    output logic cas_n_o,
    output logic we_n_o,
    output logic done_o
);
    localparam int REFI_CYC = ns_to_cyc(T_REFI_NS, CLK_NS);
    localparam int CSR_CYC  = ns_to_cyc(T_CSR_NS, CLK_NS);
    localparam int CHR_CYC  = ns_to_cyc(T_CHR_NS, CLK_NS);
    localparam int RAS_RAW  = ns_to_cyc(T_RAS_NS, CLK_NS);
    localparam int RAS_CYC  = (RAS_RAW > CHR_CYC) ? RAS_RAW : CHR_CYC + 1;
    localparam int RP_CYC   = ns_to_cyc(T_RP_NS, CLK_NS);

    logic     tick;
    logic     pending;
    logic     full;
    logic     start;
    strobes_t strobes;

    refresh_interval_timer #(.INTERVAL(REFI_CYC)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .tick_o (tick)
    );

    owed_refresh_counter #(.LIMIT(MAX_OWED)) u_owed (
        .clk       (clk),
        .rst       (rst),
        .add_i     (tick),
        .take_i    (start),
        .pending_o (pending),
        .full_o    (full)
    );

    cbr_sequencer #(
        .CSR_CYC (CSR_CYC),
        .CHR_CYC (CHR_CYC),
        .RAS_CYC (RAS_CYC),
        .RP_CYC  (RP_CYC)
    ) u_seq (
        .clk          (clk),
        .rst          (rst),
        .pending_i    (pending),
        .gnt_i        (gnt_i),
        .row_closed_i (row_closed_i),
        .req_o        (req_o),
        .start_o      (start),
        .own_o        (own_o),
        .done_o       (done_o),
        .strobes_o    (strobes)
    );

    assign urgent_o = full;
    assign ras_n_o  = strobes.ras_n;
    assign cas_n_o  = strobes.cas_n;
    assign we_n_o   = strobes.we_n;

    AST_URGENT_IMPLIES_OWED: assert property (@(posedge clk) disable iff (rst)
        urgent_o |-> (req_o || own_o)); // R8
    AST_STROBES_IDLE_FREE: assert property (@(posedge clk) disable iff (rst)
        !own_o |-> (ras_n_o && cas_n_o)); // R3
endmodule

// File: tb/tb_cbr_refresh_sched.sv
module tb_cbr_refresh_sched;
    localparam int CLK_NS  = 10;
    localparam int REFI_NS = 3000;
    localparam int REFI    = (REFI_NS + CLK_NS - 1) / CLK_NS;
    localparam int CSR     = 1;
    localparam int CHR     = 1;
    localparam int RASC    = 6;
    localparam int RPC     = 4;
    localparam int OWN_LEN = CSR + RASC + RPC;
    localparam int MAXO    = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic gnt = 1'b0;
    logic row_closed = 1'b0;
    logic req, urgent, own, ras_n, cas_n, we_n, done;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    cbr_refresh_sched #(
        .CLK_NS    (CLK_NS),
        .T_REFI_NS (REFI_NS),
        .MAX_OWED  (MAXO)
    ) dut (
        .clk          (clk),
        .rst          (rst),
        .gnt_i        (gnt),
        .row_closed_i (row_closed),
        .req_o        (req),
        .urgent_o     (urgent),
        .own_o        (own),
        .ras_n_o      (ras_n),
        .cas_n_o      (cas_n),
        .we_n_o       (we_n),
        .done_o       (done)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; gnt = 1'b0; row_closed = 1'b0;
        wait_cyc(3);
        rst = 1'b0;
    endtask

    // R1: outputs during and just after reset
    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1; gnt = 1'b1; row_closed = 1'b1;
        wait_cyc(3);
        check({ras_n, cas_n, we_n} == 3'b111, "R1 strobes in reset", {ras_n, cas_n, we_n}, 7);
        check({req, own, urgent, done} == 4'b0, "R1 flags in reset", {req, own, urgent, done}, 0);
        rst = 1'b0;
        @(negedge clk);
        check({ras_n, cas_n, we_n} == 3'b111 && {req, own, done} == 3'b0,
              "R1 first cycle after reset", {ras_n, cas_n, own}, 6);
        gnt = 1'b0; row_closed = 1'b0;
    endtask

    // R2: first request edge; then R3..R7, R9 on the refresh cycle shape
    task automatic t_interval_and_shape();
        logic own_s [20];
        logic ras_s [20];
        logic cas_s [20];
        logic we_s  [20];
        logic done_s[20];
        logic req_s [20];
        int owned;
        int dones;
        do_reset();
        wait_cyc(REFI - 2);
        check(req == 1'b0, "R2 no request before interval", req, 0);
        wait_cyc(3);
        check(req == 1'b1, "R2 request after interval", req, 1);
        // R3: grant while the row is still open must be ignored
        gnt = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (own || !ras_n || !cas_n) begin
                check(1'b0, "R3 grant with open row", own, 0);
                break;
            end
        end
        check(own == 1'b0 && req == 1'b1, "R3 request held while row open", own, 0);
        row_closed = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            own_s[i] = own; ras_s[i] = ras_n; cas_s[i] = cas_n;
            we_s[i] = we_n; done_s[i] = done; req_s[i] = req;
            if (i == 0) gnt = 1'b0;
        end
        row_closed = 1'b0;
        owned = 0; dones = 0;
        for (int i = 0; i < 20; i++) begin
            owned += int'(own_s[i]);
            dones += int'(done_s[i]);
            if (own_s[i] && !we_s[i]) check(1'b0, "R6 WE low while owned", i, -1);
            if (own_s[i] && req_s[i]) check(1'b0, "R9 request during cycle", i, -1);
        end
        check(owned == OWN_LEN, "R5 owned length", owned, OWN_LEN);
        check(dones == 1, "R7 one done per refresh", dones, 1);
        check(done_s[OWN_LEN-1] == 1'b1, "R7 done on last owned cycle", done_s[OWN_LEN-1], 1);
        for (int i = 0; i < CSR; i++)
            check(own_s[i] && !cas_s[i] && ras_s[i], "R4 CAS leads RAS", {ras_s[i], cas_s[i]}, 2);
        for (int i = CSR; i < CSR + RASC; i++) begin
            check(!ras_s[i], "R5 RAS low phase", ras_s[i], 0);
            check(cas_s[i] == (i >= CSR + CHR), "R4 CAS hold after RAS fall",
                  cas_s[i], int'(i >= CSR + CHR));
        end
        for (int i = CSR + RASC; i < OWN_LEN; i++)
            check(own_s[i] && ras_s[i] && cas_s[i], "R5 precharge strobes high",
                  {own_s[i], ras_s[i], cas_s[i]}, 7);
        check(!own_s[OWN_LEN] && !req_s[OWN_LEN], "R9 released with nothing owed",
              {own_s[OWN_LEN], req_s[OWN_LEN]}, 0);
        check(we_s[0] && we_s[CSR], "R6 WE high around RAS fall", we_s[CSR], 1);
    endtask

    // R8: saturation, urgency and drain of a full backlog
    task automatic t_saturate();
        int dones;
        do_reset();
        wait_cyc(7 * REFI + 10);
        check(urgent == 1'b0 && req == 1'b1, "R8 not urgent at seven owed", urgent, 0);
        wait_cyc(2 * REFI + 10);
        check(urgent == 1'b1, "R8 urgent at limit", urgent, 1);
        gnt = 1'b1; row_closed = 1'b1;
        dones = 0;
        for (int i = 0; i < 150; i++) begin
            @(negedge clk);
            dones += int'(done);
        end
        gnt = 1'b0; row_closed = 1'b0;
        check(dones == MAXO, "R8 drained refresh count", dones, MAXO);
        check(req == 1'b0 && urgent == 1'b0, "R8 backlog empty", {req, urgent}, 0);
    endtask

    // R9: back-to-back refreshes with a request returning after done
    task automatic t_back_to_back();
        int dones;
        int starts;
        bit req_after_done;
        do_reset();
        wait_cyc(2 * REFI + 10);
        gnt = 1'b1; row_closed = 1'b1;
        dones = 0; starts = 0; req_after_done = 1'b0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (dones == 1 && !own && req) req_after_done = 1'b1;
            dones  += int'(done);
        end
        gnt = 1'b0; row_closed = 1'b0;
        check(dones == 2, "R9 two owed give two refreshes", dones, 2);
        check(req_after_done, "R9 request back after first done", req_after_done, 1);
        check(req == 1'b0, "R9 request low when count is zero", req, 0);
        starts = starts;
    endtask

    initial begin
        t_reset();
        t_interval_and_shape();
        t_saturate();
        t_back_to_back();
        finished = 1'b1;
    end

    initial begin
        fork
            wait (finished);
            begin
                repeat (100000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule